// File: doc/BRIEF.md
# Host control register slave

This block sits on a memory-mapped host bus clocked by the host interface clock. It turns host writes into three kinds of control for user logic. A command word at word address 0 starts timed pulses and flips held enables. A bank of 32-bit configuration words can be written and read back. Each configuration word drives user logic directly.

The slave handles single and burst transfers. A burst's length is taken from the burst count on its first beat, and later beats move to the next word addresses. The slave raises its wait signal for exactly one cycle on the first beat of every transaction, so the master always sees the stall path. Read data comes back with a valid strobe one cycle after the read is accepted. A read burst then returns one word per cycle.

Clock domain crossing into the user clock is done outside this block, as is arbitration between several masters.

Top module: `ctl_regslave`

## Requirements
- R1: After reset, `bus_wait` and `bus_rvalid` are low, `enable_out` is 0, the pulse output is at its inactive level, and every configuration word is zero.
- R2: On the first beat of every transaction, a read or write arriving while the slave is idle, `bus_wait` is high for exactly one cycle. The later beats of a write burst are accepted with no stall.
- R3: A write burst applies its beats to consecutive word addresses starting at `bus_addr`. The length is sampled on the first beat, and a burst count of 0 is treated as 1.
- R4: An accepted read raises `bus_rvalid` on the following cycle. A read burst of N words returns them on N consecutive cycles from consecutive addresses, and `bus_rvalid` falls after the last word.
- R5: A write to word 0 with data bit 0 set and byte lane 0 enabled makes the pulse output active for PULSE_LEN cycles (10 by default), starting the cycle after the write is accepted.
- R6: A new pulse command while a pulse is active reloads the full PULSE_LEN length.
- R7: PULSE_ACTIVE_HIGH=1 makes the pulse output high while active. With 0 it is low while active and high when idle.
- R8: A write to word 0 with data bit 1 set and byte lane 0 enabled inverts `enable_out`, which otherwise holds its level. A read of word 0 returns `enable_out` in bit 1 and zero in every other bit.
- R9: Configuration word i sits at word address 1+i (1 to 4 by default). Byte lane b of `bus_be` gates data bits 8b+7:8b. The words appear on `cfg_out` with word i in bits 32i+31:32i, and they read back unchanged.
- R10: Command bits have no effect when byte lane 0 is disabled.
- R11: Unmapped word addresses (5 to 15 by default) read as zero, and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host interface clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Word address of the first beat |
| bus_write | input | 1 | Write request, data valid only while high |
| bus_read | input | 1 | Read request |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Byte lane enables |
| bus_burstcnt | input | BURST_W | Beats in the transaction (0 means 1) |
| bus_wait | output | 1 | Stall; the beat is not taken while high |
| bus_rdata | output | DATA_W | Read data |
| bus_rvalid | output | 1 | Read data valid |
| pulse_out | output | 1 | Stretched command pulse |
| enable_out | output | 1 | Held enable level |
| cfg_out | output | N_CFG*DATA_W | Configuration words, word i at bits 32i+31:32i |

## Verification
A write beat takes effect at the clock edge that accepts it. Its effect on `enable_out`, `cfg_out` and the pulse output can therefore be seen half a cycle later, at the falling edge where the bench ends the write. At that same falling edge the bench starts counting the pulse, and it expects exactly PULSE_LEN active falling edges. For reads, the bench treats the edge with the request high and the wait low as acceptance, and compares word k at the (k+1)-th falling edge after it. The bench samples the combinational wait signal 1 ns after it drives each beat, to count stalls beat by beat. All inputs are driven and all outputs sampled on falling edges.

// File: rtl/ctl_regslave_pkg.sv
package ctl_regslave_pkg;

    // bus sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a first beat (stalls it)
        ST_ACT   = 2'd1,   // accepting write beats or the read command
        ST_RDATA = 2'd2    // returning remaining read burst words
    } bus_st_e;

endpackage

// File: rtl/ctl_pulse_stretch.sv
module ctl_pulse_stretch #(
    parameter int LEN         = 10,
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic pulse_o
);
    localparam int CNT_W = $clog2(LEN + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trig_i) begin
            cnt_d = CNT_W'(LEN);           // reload also on re-trigger
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (ACTIVE_HIGH) begin : g_hi
            assign pulse_o = (cnt_q != '0);
        end else begin : g_lo
            assign pulse_o = (cnt_q == '0);
        end
    endgenerate
endmodule

// File: rtl/ctl_level_toggle.sv
module ctl_level_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic flip_i,
    output logic level_o
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = flip_i ? ~lvl_q : lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign level_o = lvl_q;
endmodule

// File: rtl/ctl_cfg_word.sv
module ctl_cfg_word #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W/8-1:0] be_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] q_o
);
    localparam int BE_W = DATA_W / 8;

    logic [DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        for (int b = 0; b < BE_W; b++) begin
            if (we_i && be_i[b]) word_d[8*b +: 8] = wdata_i[8*b +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign q_o = word_q;
endmodule

// File: rtl/ctl_regslave.sv
module ctl_regslave
    import ctl_regslave_pkg::*;
#(
    parameter int ADDR_W            = 4,
    parameter int DATA_W            = 32,
    parameter int BURST_W           = 4,
    parameter int N_CFG             = 4,
    parameter int PULSE_LEN         = 10,
    parameter bit PULSE_ACTIVE_HIGH = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_write,
    input  logic                    bus_read,
    input  logic [DATA_W-1:0]       bus_wdata,
    input  logic [DATA_W/8-1:0]     bus_be,
    input  logic [BURST_W-1:0]      bus_burstcnt,
    output logic                    bus_wait,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_rvalid,
    output logic                    pulse_out,
    output logic                    enable_out,
    output logic [N_CFG*DATA_W-1:0] cfg_out
);
    localparam int CMD_ADDR  = 0;
    localparam int CFG_BASE  = 1;
    localparam int PULSE_BIT = 0;
    localparam int FLIP_BIT  = 1;
    localparam int PULSE_LN  = PULSE_BIT / 8;
    localparam int FLIP_LN   = FLIP_BIT / 8;

    typedef struct packed {
        bus_st_e             st;
        logic [ADDR_W-1:0]   ptr;
        logic [BURST_W-1:0]  left;
        logic                is_rd;
        logic                rvalid;
        logic [DATA_W-1:0]   rdata;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              wait_c;
    logic              wr_beat;
    logic              hit_cmd;
    logic [N_CFG-1:0]  hit_cfg;
    logic [DATA_W-1:0] rd_word;
    logic              trig, flip;
    logic [DATA_W-1:0] cfg_q [N_CFG];

    // address decode on the current beat pointer
    assign hit_cmd = (seq_q.ptr == ADDR_W'(CMD_ADDR));
    generate
        for (genvar i = 0; i < N_CFG; i++) begin : g_dec
            assign hit_cfg[i] = (seq_q.ptr == ADDR_W'(CFG_BASE + i));
        end
    endgenerate

    always_comb begin
        rd_word = '0;
        if (hit_cmd) rd_word[FLIP_BIT] = enable_out;
        for (int i = 0; i < N_CFG; i++) begin
            if (hit_cfg[i]) rd_word = cfg_q[i];
        end
    end

    // bus sequencer
    always_comb begin
        seq_d        = seq_q;
        seq_d.rvalid = 1'b0;
        wait_c       = 1'b0;
        wr_beat      = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (bus_write || bus_read) begin
                    wait_c      = 1'b1;
                    seq_d.st    = ST_ACT;
                    seq_d.ptr   = bus_addr;
                    seq_d.left  = (bus_burstcnt == '0) ? BURST_W'(1) : bus_burstcnt;
                    seq_d.is_rd = bus_read && !bus_write;
                end
            end
            ST_ACT: begin
                if (seq_q.is_rd) begin
                    if (bus_read) begin
                        seq_d.rvalid = 1'b1;
                        seq_d.rdata  = rd_word;
                        seq_d.ptr    = seq_q.ptr + ADDR_W'(1);
                        seq_d.left   = seq_q.left - BURST_W'(1);
                        seq_d.st     = (seq_q.left == BURST_W'(1)) ? ST_IDLE : ST_RDATA;
                    end
                end else if (bus_write) begin
                    wr_beat    = 1'b1;
                    seq_d.ptr  = seq_q.ptr + ADDR_W'(1);
                    seq_d.left = seq_q.left - BURST_W'(1);
                    seq_d.st   = (seq_q.left == BURST_W'(1)) ? ST_IDLE : ST_ACT;
                end
            end
            ST_RDATA: begin
                wait_c       = 1'b1;
                seq_d.rvalid = 1'b1;
                seq_d.rdata  = rd_word;
                seq_d.ptr    = seq_q.ptr + ADDR_W'(1);
                seq_d.left   = seq_q.left - BURST_W'(1);
                seq_d.st     = (seq_q.left == BURST_W'(1)) ? ST_IDLE : ST_RDATA;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign bus_wait   = wait_c;
    assign bus_rvalid = seq_q.rvalid;
    assign bus_rdata  = seq_q.rdata;

    // command word decode
    assign trig = wr_beat && hit_cmd && bus_be[PULSE_LN] && bus_wdata[PULSE_BIT];
    assign flip = wr_beat && hit_cmd && bus_be[FLIP_LN]  && bus_wdata[FLIP_BIT];

    ctl_pulse_stretch #(
        .LEN         (PULSE_LEN),
        .ACTIVE_HIGH (PULSE_ACTIVE_HIGH)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (trig),
        .pulse_o (pulse_out)
    );

    ctl_level_toggle u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .flip_i  (flip),
        .level_o (enable_out)
    );

    generate
        for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
            ctl_cfg_word #(.DATA_W(DATA_W)) u_word (
                .clk     (clk),
                .rst_n   (rst_n),
                .we_i    (wr_beat && hit_cfg[i]),
                .be_i    (bus_be),
                .wdata_i (bus_wdata),
                .q_o     (cfg_q[i])
            );
            assign cfg_out[DATA_W*i +: DATA_W] = cfg_q[i];
        end
    endgenerate
endmodule

// File: rtl/ctl_regslave_chk.sv
module ctl_regslave_chk #(
    parameter int DATA_W            = 32,
    parameter int N_CFG             = 4,
    parameter bit PULSE_ACTIVE_HIGH = 1'b1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_write,
    input logic                    bus_read,
    input logic                    bus_wait,
    input logic                    bus_rvalid,
    input logic                    pulse_out,
    input logic                    enable_out,
    input logic [N_CFG*DATA_W-1:0] cfg_out
);
    logic req, wr_acc, rd_acc, p_act;
    assign req    = bus_write || bus_read;
    assign wr_acc = bus_write && !bus_wait;
    assign rd_acc = bus_read && !bus_write && !bus_wait;
    assign p_act  = PULSE_ACTIVE_HIGH ? pulse_out : !pulse_out;

    // R2: a request following an idle bus cycle is stalled (master keeps beats back to back)
    assert_first_beat_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !$past(req)) |-> bus_wait);

    // R4: read data valid one cycle after acceptance
    assert_rvalid_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> bus_rvalid);

    // R4: valid data only follows a read or continues a burst
    assert_rvalid_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> ($past(bus_read) || $past(bus_rvalid)));

    // R5: a pulse starts only after an accepted write
    assert_pulse_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_act) |-> $past(wr_acc));

    // R8: enable holds unless a write was accepted
    assert_enable_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_acc) |-> $stable(enable_out));

    // R9: configuration words hold unless a write was accepted
    assert_cfg_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_acc) |-> $stable(cfg_out));
endmodule

bind ctl_regslave ctl_regslave_chk #(
    .DATA_W            (DATA_W),
    .N_CFG             (N_CFG),
    .PULSE_ACTIVE_HIGH (PULSE_ACTIVE_HIGH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_write  (bus_write),
    .bus_read   (bus_read),
    .bus_wait   (bus_wait),
    .bus_rvalid (bus_rvalid),
    .pulse_out  (pulse_out),
    .enable_out (enable_out),
    .cfg_out    (cfg_out)
);

// File: tb/ctl_regslave_bench.sv
module ctl_regslave_bench;
    localparam int PLEN = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic         bus_write = 1'b0;
    logic         bus_read = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [3:0]   bus_be = '0;
    logic [3:0]   bus_burstcnt = '0;
    logic         bus_wait, bus_rvalid, pulse_out, enable_out;
    logic [31:0]  bus_rdata;
    logic [127:0] cfg_out;
    logic         n_wait, n_rvalid, n_pulse, n_enable;
    logic [31:0]  n_rdata;
    logic [127:0] n_cfg;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] wbuf [8];
    logic [31:0] ebuf [8];
    logic [31:0] m_cfg [4];

    always #5 clk = ~clk;

    ctl_regslave #(.PULSE_LEN(PLEN)) u_ctl_regslave (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_read(bus_read), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_burstcnt(bus_burstcnt), .bus_wait(bus_wait), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pulse_out(pulse_out), .enable_out(enable_out),
        .cfg_out(cfg_out));

    // active-low pulse variant on the same bus
    ctl_regslave #(.PULSE_LEN(PLEN), .PULSE_ACTIVE_HIGH(1'b0)) u_ctl_regslave_lo (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_read(bus_read), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_burstcnt(bus_burstcnt), .bus_wait(n_wait), .bus_rdata(n_rdata),
        .bus_rvalid(n_rvalid), .pulse_out(n_pulse), .enable_out(n_enable),
        .cfg_out(n_cfg));

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
        merge = old;
        for (int b = 0; b < 4; b++) if (be[b]) merge[8*b +: 8] = nw[8*b +: 8];
    endfunction

    function automatic logic [127:0] model_cfg();
        model_cfg = {m_cfg[3], m_cfg[2], m_cfg[1], m_cfg[0]};
    endfunction

    // write burst of n beats from wbuf; checks the one-cycle first-beat stall (R2)
    task automatic bus_wr(input logic [3:0] a, input int n, input logic [3:0] bc, input logic [3:0] be);
        int  i = 0;
        int  stalls = 0;
        bit  first_stalled = 1'b0;
        bit  acc;
        @(negedge clk);
        bus_addr = a; bus_write = 1'b1; bus_burstcnt = bc; bus_be = be; bus_wdata = wbuf[0];
        while (i < n) begin
            #1;
            acc = !bus_wait;
            if (!acc) begin
                stalls++;
                if (i == 0) first_stalled = 1'b1;
            end
            @(negedge clk);
            if (acc) begin
                i++;
                if (i < n) bus_wdata = wbuf[i];
                else bus_write = 1'b0;
            end
        end
        chk(stalls == 1 && first_stalled, "R2 write stall count", stalls, 1);
    endtask

    // read burst of n beats, compared against ebuf (R4)
    task automatic bus_rd(input logic [3:0] a, input int n, input string tag);
        bit acc = 1'b0;
        int stalls = 0;
        @(negedge clk);
        bus_addr = a; bus_read = 1'b1; bus_burstcnt = 4'(n);
        while (!acc) begin
            #1;
            acc = !bus_wait;
            if (!acc) stalls++;
            @(negedge clk);
        end
        bus_read = 1'b0;
        chk(stalls == 1, "R2 read stall count", stalls, 1);
        for (int k = 0; k < n; k++) begin
            chk(bus_rvalid == 1'b1, "R4 rvalid during burst", bus_rvalid, 1);
            chk(bus_rdata == ebuf[k], tag, bus_rdata, ebuf[k]);
            @(negedge clk);
        end
        chk(bus_rvalid == 1'b0, "R4 rvalid drops after burst", bus_rvalid, 0);
    endtask

    task automatic count_pulse(output int c);
        c = 0;
        while (pulse_out && c < 100) begin
            c++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(bus_wait == 0 && bus_rvalid == 0, "R1 bus idle after reset", {bus_wait, bus_rvalid}, 0);
        chk(pulse_out == 0, "R1 pulse inactive after reset", pulse_out, 0);
        chk(n_pulse == 1, "R7 active-low pulse idles high", n_pulse, 1);
        chk(enable_out == 0, "R1 enable clear after reset", enable_out, 0);
        chk(cfg_out == '0, "R1 cfg zero after reset", cfg_out, 0);
    endtask

    task automatic t_cfg_burst();
        for (int k = 0; k < 4; k++) begin
            wbuf[k] = 32'hC0DE_0000 + 32'(k * 32'h1111);
            m_cfg[k] = wbuf[k];
            ebuf[k] = wbuf[k];
        end
        bus_wr(4'd1, 4, 4'd4, 4'hF);
        chk(cfg_out == model_cfg(), "R3 burst write consecutive words", cfg_out, model_cfg());
        bus_rd(4'd1, 4, "R9 cfg burst readback");
    endtask

    task automatic t_byte_lanes();
        wbuf[0] = 32'hAABB_CCDD;
        m_cfg[1] = merge(m_cfg[1], wbuf[0], 4'b0101);
        bus_wr(4'd2, 1, 4'd1, 4'b0101);
        chk(cfg_out == model_cfg(), "R9 byte lane masking", cfg_out, model_cfg());
        ebuf[0] = m_cfg[1];
        bus_rd(4'd2, 1, "R9 masked word readback");
    endtask

    task automatic t_burst_zero();
        wbuf[0] = 32'h5555_0000;
        wbuf[1] = 32'hDEAD_BEEF;
        m_cfg[3] = wbuf[0];
        bus_wr(4'd4, 1, 4'd0, 4'hF);
        chk(cfg_out == model_cfg(), "R3 burst count 0 is one beat", cfg_out, model_cfg());
        @(negedge clk);
        chk(bus_wait == 0 && cfg_out == model_cfg(), "R3 no second beat taken", cfg_out, model_cfg());
    endtask

    task automatic t_unmapped();
        wbuf[0] = 32'h1234_5678;
        bus_wr(4'd9, 1, 4'd1, 4'hF);
        chk(cfg_out == model_cfg(), "R11 unmapped write no effect", cfg_out, model_cfg());
        chk(enable_out == 0 && pulse_out == 0, "R11 unmapped write no control", {enable_out, pulse_out}, 0);
        ebuf[0] = '0;
        bus_rd(4'd9, 1, "R11 unmapped read zero");
        ebuf[0] = m_cfg[2]; ebuf[1] = m_cfg[3]; ebuf[2] = '0;
        bus_rd(4'd3, 3, "R4 burst read across map end");
    endtask

    task automatic t_pulse();
        int c;
        wbuf[0] = 32'h0000_0001;
        bus_wr(4'd0, 1, 4'd1, 4'b0001);
        chk(n_pulse == 0, "R7 active-low pulse low while active", n_pulse, 0);
        count_pulse(c);
        chk(c == PLEN, "R5 pulse length", c, PLEN);
        chk(enable_out == 0, "R8 pulse command leaves enable", enable_out, 0);
    endtask

    task automatic t_retrigger();
        int c;
        wbuf[0] = 32'h0000_0001;
        bus_wr(4'd0, 1, 4'd1, 4'b0001);
        repeat (4) @(negedge clk);
        bus_wr(4'd0, 1, 4'd1, 4'b0001);
        count_pulse(c);
        chk(c == PLEN, "R6 retrigger reloads full length", c, PLEN);
    endtask

    task automatic t_enable();
        wbuf[0] = 32'h0000_0002;
        bus_wr(4'd0, 1, 4'd1, 4'b0001);
        chk(enable_out == 1, "R8 toggle sets enable", enable_out, 1);
        chk(pulse_out == 0, "R8 toggle does not pulse", pulse_out, 0);
        repeat (5) @(negedge clk);
        chk(enable_out == 1, "R8 enable holds", enable_out, 1);
        ebuf[0] = 32'h0000_0002;
        bus_rd(4'd0, 1, "R8 command word readback");
        bus_wr(4'd0, 1, 4'd1, 4'b0001);
        chk(enable_out == 0, "R8 toggle clears enable", enable_out, 0);
    endtask

    task automatic t_lane_off();
        wbuf[0] = 32'h0000_0003;
        bus_wr(4'd0, 1, 4'd1, 4'b1110);
        chk(pulse_out == 0, "R10 pulse ignored lane off", pulse_out, 0);
        chk(enable_out == 0, "R10 toggle ignored lane off", enable_out, 0);
        @(negedge clk);
        chk(pulse_out == 0 && enable_out == 0, "R10 still no effect", {enable_out, pulse_out}, 0);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) m_cfg[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_burst();
        t_byte_lanes();
        t_burst_zero();
        t_unmapped();
        t_pulse();
        t_retrigger();
        t_enable();
        t_lane_off();
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule